// File: doc/BRIEF.md
# Sync-Hunting Character Receiver with Transmit Alignment

This block is the front end of a character-synchronous serial receiver. It shifts serial data in on a bit-clock enable and searches that stream for a programmed sync character. While it searches it is in Hunt. When it finds the character it leaves Hunt and from then on cuts the stream into fixed-width characters on the boundary it has found. Each complete character is presented on a parallel output with a one-cycle valid strobe.

Two variants sit beside plain hunting. In external-start mode the pattern search is bypassed. Bits are accumulated only while an active-low start pin is held low, and a rising pin discards any partly assembled character. In alignment mode the local transmit bit stream idles at a selectable level while the receiver hunts. Exactly one character time after sync is found, the transmit stream starts sending the sync character, bit for bit in step with the received character boundaries.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset the block is in Hunt (`in_hunt`=1), `char_vld`=0, `tx_active`=0 and `tx_bit` equals `idle_ones`.
- R2: In mode 0 (hunt) and mode 2 (align), the block leaves Hunt on the bit enable at which the last 8 sampled bits equal `sync_pat`. The earliest of those bits is compared with bit 0. `in_hunt` reads 0 from the next cycle on, and stays 1 at every earlier bit.
- R3: While `in_hunt` is 1 in modes 0 and 2, `char_vld` never pulses.
- R4: Out of Hunt, each group of 8 sampled bits is delivered on `char_out`, with the first bit received in bit 0. `char_vld` is high for exactly the one cycle after the enable of the 8th bit.
- R5: A `hunt_cmd` pulse returns the block to Hunt and discards the partial character. The next character is framed from the next sync match.
- R6: While `rx_en` is 0 the block is held in Hunt, a sync match is ignored and no character is delivered.
- R7: In mode 1 (external start), a high `ext_sync_n` holds Hunt and delivers nothing, whatever the data. Bits sampled while it is low are assembled into characters as in R4, and `in_hunt` follows the pin one cycle later.
- R8: In mode 1, raising `ext_sync_n` mid-character discards the partial bits. The next character is assembled from the bits sampled after the pin falls again.
- R9: In mode 2, while in Hunt, `tx_active` is 0 and `tx_bit` equals `idle_ones`.
- R10: In mode 2, `tx_active` rises in the same cycle as the first `char_vld` after sync. From then on, while the receiver awaits bit k of a character, `tx_bit` equals `sync_pat[k]`.
- R11: In modes 0 and 1, `tx_active` stays 0 and `tx_bit` equals `idle_ones`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; low holds Hunt |
| hunt_cmd | input | 1 | One-cycle command to re-enter Hunt |
| mode_sel | input | 2 | 0 hunt, 1 external start, 2 align, 3 as 0 |
| sync_pat | input | 8 | Sync character, bit 0 received first |
| ext_sync_n | input | 1 | Active-low external start pin |
| idle_ones | input | 1 | Transmit idle level: 1 sends ones, 0 sends zeros |
| bit_en | input | 1 | Bit clock enable; one data bit per high cycle |
| rx_bit | input | 1 | Serial receive data |
| char_out | output | 8 | Last assembled character |
| char_vld | output | 1 | One-cycle strobe for `char_out` |
| in_hunt | output | 1 | High while searching for a boundary |
| tx_bit | output | 1 | Transmit bit stream |
| tx_active | output | 1 | Transmitter sending sync characters |

## Verification
The hardest point to reach is the transmit handover in alignment mode. A sync match must first occur, then a full character of received bits must follow. The bench has to look at the transmit bit before every single received bit of that character to show that the transmitter is still idle, and then again across the next character to show that each transmit bit lines up with the receive bit index. The stimulus gets there with a sync task that precedes the pattern with an all-ones byte. No window formed from leftover bits can then match early, so the boundary lands on a known bit and each per-bit sample can be predicted exactly.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

    typedef enum logic [1:0] {
        MODE_HUNT  = 2'd0,
        MODE_EXT   = 2'd1,
        MODE_ALIGN = 2'd2,
        MODE_SPARE = 2'd3
    } rx_mode_e;

    localparam int DEF_CHAR_W = 8;

    function automatic logic uses_pattern(input rx_mode_e m);
        return (m != MODE_EXT);
    endfunction

endpackage

// File: rtl/hunt_window.sv
module hunt_window #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_en,
    input  logic         rx_bit,
    input  logic [W-1:0] pattern,
    output logic [W-1:0] win_next,
    output logic         match
);
    logic [W-1:0] win;

    // newest bit enters at the top; after W shifts the first bit sits in bit 0
    assign win_next = {rx_bit, win[W-1:1]};
    assign match    = bit_en && (win_next == pattern);

    always_ff @(posedge clk) begin
        if (rst)
            win <= '0;
        else if (bit_en)
            win <= win_next;
    end

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        bit_en |=> (win[W-1] == $past(rx_bit)));

endmodule

// File: rtl/char_counter.sv
module char_counter #(
    parameter int W = 8,
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    input  logic [W-1:0]     win_next,
    output logic [W-1:0]     char_out,
    output logic             char_vld,
    output logic [CNT_W-1:0] bit_idx,
    output logic             boundary
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    assign boundary = advance && !clear && (bit_idx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_idx  <= '0;
            char_out <= '0;
            char_vld <= 1'b0;
        end else begin
            char_vld <= boundary;
            if (clear)
                bit_idx <= '0;
            else if (advance) begin
                if (bit_idx == LAST) begin
                    bit_idx  <= '0;
                    char_out <= win_next;
                end else
                    bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // R4
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        char_vld |=> !char_vld);

endmodule

// File: rtl/tx_align.sv
module tx_align #(
    parameter int W = 8,
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             boundary,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic [W-1:0]     pattern,
    input  logic             idle_ones,
    output logic             tx_bit,
    output logic             tx_active
);
    always_ff @(posedge clk) begin
        if (rst)
            tx_active <= 1'b0;
        else if (!arm)
            tx_active <= 1'b0;
        else if (boundary)
            tx_active <= 1'b1;
    end

    // transmit bit k while the receiver waits for bit k
    assign tx_bit = tx_active ? pattern[bit_idx] : idle_ones;

endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx
    import sync_hunt_pkg::*;
#(
    parameter int CHAR_W = DEF_CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              hunt_cmd,
    input  logic [1:0]        mode_sel,
    input  logic [CHAR_W-1:0] sync_pat,
    input  logic              ext_sync_n,
    input  logic              idle_ones,
    input  logic              bit_en,
    input  logic              rx_bit,
    output logic [CHAR_W-1:0] char_out,
    output logic              char_vld,
    output logic              in_hunt,
    output logic              tx_bit,
    output logic              tx_active
);
    localparam int CNT_W = (CHAR_W > 1) ? $clog2(CHAR_W) : 1;

    rx_mode_e          mode;
    logic              force_hunt;
    logic              sync_hit;
    logic [CHAR_W-1:0] win_next;
    logic              cnt_clear;
    logic              boundary;
    logic [CNT_W-1:0]  bit_idx;
    logic              arm;

    assign mode       = rx_mode_e'(mode_sel);
    assign force_hunt = !rx_en || hunt_cmd;

    hunt_window #(.W(CHAR_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .rx_bit   (rx_bit),
        .pattern  (sync_pat),
        .win_next (win_next),
        .match    (sync_hit)
    );

    always_ff @(posedge clk) begin
        if (rst)
            in_hunt <= 1'b1;
        else if (force_hunt)
            in_hunt <= 1'b1;
        else if (!uses_pattern(mode))
            in_hunt <= ext_sync_n;
        else if (in_hunt && sync_hit)
            in_hunt <= 1'b0;
    end

    // counter runs only once a boundary is known (or the pin is low)
    assign cnt_clear = force_hunt || (uses_pattern(mode) ? in_hunt : ext_sync_n);

    char_counter #(.W(CHAR_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear    (cnt_clear),
        .advance  (bit_en),
        .win_next (win_next),
        .char_out (char_out),
        .char_vld (char_vld),
        .bit_idx  (bit_idx),
        .boundary (boundary)
    );

    assign arm = (mode == MODE_ALIGN) && !in_hunt && !force_hunt;

    tx_align #(.W(CHAR_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .arm       (arm),
        .boundary  (boundary),
        .bit_idx   (bit_idx),
        .pattern   (sync_pat),
        .idle_ones (idle_ones),
        .tx_bit    (tx_bit),
        .tx_active (tx_active)
    );

    // R2
    stay_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        (in_hunt && uses_pattern(mode) && !force_hunt && !sync_hit) |=> in_hunt);

    // R6
    disabled_hunt_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (in_hunt && !char_vld));

    // R7
    ext_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_EXT && ext_sync_n && rx_en) |=> !char_vld);

    // R9
    hunt_tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        in_hunt |-> !tx_active);

    // R10
    tx_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_active) |-> char_vld);

endmodule

// File: tb/sim_sync_hunt_rx.sv
module sim_sync_hunt_rx;
    localparam int W = 8;
    localparam logic [7:0] PAT = 8'h16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rx_en = 1'b1;
    logic         hunt_cmd = 1'b0;
    logic [1:0]   mode_sel = 2'd0;
    logic [W-1:0] sync_pat = PAT;
    logic         ext_sync_n = 1'b1;
    logic         idle_ones = 1'b1;
    logic         bit_en = 1'b0;
    logic         rx_bit = 1'b0;
    logic [W-1:0] char_out;
    logic         char_vld;
    logic         in_hunt;
    logic         tx_bit;
    logic         tx_active;

    int checks = 0;
    int failures = 0;
    int vld_cnt = 0;
    int cyc = 0;
    logic [W-1:0] got_char = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sync_hunt_rx u0 (
        .clk(clk), .rst(rst), .rx_en(rx_en), .hunt_cmd(hunt_cmd),
        .mode_sel(mode_sel), .sync_pat(sync_pat), .ext_sync_n(ext_sync_n),
        .idle_ones(idle_ones), .bit_en(bit_en), .rx_bit(rx_bit),
        .char_out(char_out), .char_vld(char_vld), .in_hunt(in_hunt),
        .tx_bit(tx_bit), .tx_active(tx_active)
    );

    always @(negedge clk) begin
        if (char_vld) begin
            vld_cnt  <= vld_cnt + 1;
            got_char <= char_out;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            report();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        #1;
    endtask

    task automatic send_byte(input logic [7:0] d);
        for (int k = 0; k < 8; k++) send_bit(d[k]);
    endtask

    task automatic pulse_hunt();
        @(negedge clk);
        hunt_cmd = 1'b1;
        @(negedge clk);
        hunt_cmd = 1'b0;
        #1;
    endtask

    // all-ones preamble then sync pattern; checks R2/R3 along the way
    task automatic send_sync(input bit expect_lock);
        int v0;
        v0 = vld_cnt;
        send_byte(8'hFF);
        for (int k = 0; k < 7; k++) send_bit(PAT[k]);
        check("R2 hunt before last bit", in_hunt, 1);
        send_bit(PAT[7]);
        check("R2 hunt after match", in_hunt, expect_lock ? 0 : 1);
        check("R3 no char while hunting", vld_cnt - v0, 0);
    endtask

    task automatic t_reset();
        idle(3);
        rst = 1'b0;
        idle(1);
        check("R1 in_hunt", in_hunt, 1);
        check("R1 char_vld", char_vld, 0);
        check("R1 tx_active", tx_active, 0);
        check("R1 tx_bit", tx_bit, 1);
    endtask

    task automatic t_hunt_basic();
        int v0;
        mode_sel = 2'd0;
        send_sync(1);
        v0 = vld_cnt;
        send_byte(8'hA5);
        check("R4 char A5", got_char, 8'hA5);
        check("R4 count", vld_cnt - v0, 1);
        send_byte(8'h3C);
        check("R4 char 3C", got_char, 8'h3C);
        check("R4 count two", vld_cnt - v0, 2);
        check("R11 tx_active mode0", tx_active, 0);
        check("R11 tx_bit mode0", tx_bit, 1);
    endtask

    task automatic t_hunt_cmd();
        int v0;
        send_bit(1); send_bit(0); send_bit(1);
        pulse_hunt();
        check("R5 back in hunt", in_hunt, 1);
        v0 = vld_cnt;
        send_sync(1);
        check("R5 partial discarded", vld_cnt - v0, 0);
        send_byte(8'h5A);
        check("R5 realigned char", got_char, 8'h5A);
        check("R5 count", vld_cnt - v0, 1);
    endtask

    task automatic t_disable();
        int v0;
        @(negedge clk);
        rx_en = 1'b0;
        idle(1);
        check("R6 hunt on disable", in_hunt, 1);
        v0 = vld_cnt;
        send_sync(0);
        send_byte(8'h77);
        check("R6 still hunting", in_hunt, 1);
        check("R6 no chars", vld_cnt - v0, 0);
        @(negedge clk);
        rx_en = 1'b1;
        idle(1);
    endtask

    task automatic t_ext();
        int v0;
        mode_sel = 2'd1;
        ext_sync_n = 1'b1;
        idle(2);
        v0 = vld_cnt;
        send_sync(0);
        check("R7 pattern ignored", in_hunt, 1);
        check("R7 no chars while high", vld_cnt - v0, 0);
        @(negedge clk);
        ext_sync_n = 1'b0;
        idle(1);
        check("R7 in_hunt follows pin", in_hunt, 0);
        send_byte(8'hC3);
        check("R7 char C3", got_char, 8'hC3);
        check("R7 count", vld_cnt - v0, 1);
        send_bit(1); send_bit(1); send_bit(1); send_bit(1);
        @(negedge clk);
        ext_sync_n = 1'b1;
        idle(2);
        check("R8 hunt on pin high", in_hunt, 1);
        @(negedge clk);
        ext_sync_n = 1'b0;
        send_byte(8'h81);
        check("R8 char 81", got_char, 8'h81);
        check("R8 count", vld_cnt - v0, 2);
        check("R11 tx_active mode1", tx_active, 0);
        @(negedge clk);
        ext_sync_n = 1'b1;
        idle(1);
    endtask

    task automatic t_align(input logic idle_lvl);
        int v0;
        int bad;
        mode_sel = 2'd2;
        idle_ones = idle_lvl;
        pulse_hunt();
        check("R9 tx idle level", tx_bit, idle_lvl);
        check("R9 tx inactive", tx_active, 0);
        send_sync(1);
        v0 = vld_cnt;
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            if (tx_active !== 1'b0 || tx_bit !== idle_lvl) bad++;
            send_bit(k[0]);
        end
        check("R10 idle for one char time", bad, 0);
        check("R10 tx started", tx_active, 1);
        check("R10 same cycle as char", vld_cnt - v0, 1);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            if (tx_bit !== PAT[k]) bad++;
            send_bit(1'b1);
        end
        check("R10 tx bits track rx index", bad, 0);
        check("R4 char FF", got_char, 8'hFF);
    endtask

    initial begin
        t_reset();
        t_hunt_basic();
        t_hunt_cmd();
        t_disable();
        t_ext();
        t_align(1'b1);
        t_align(1'b0);
        report();
    end

endmodule